// File: doc/BRIEF.md
# Configuration Access Router

This block accepts one configuration access at a time and splits its 24-bit address into a bus number, a device/function field and a register offset. It then routes the access to one of several function register spaces that it holds. Some of these functions sit on the segment directly attached to the router, whose number comes in on an input pin. The rest sit behind a bridge function, on a secondary segment whose number is held in the router.

The bridge function is one of the local functions. Writes to it that cover the secondary-bus byte of its register space update the secondary bus number. Until that number is nonzero, nothing is routed to the secondary segment.

When an access names a bus that matches neither segment, or a device/function with no function behind it, it reads back as all-ones sized to the access width, and a write is dropped. Reads answer one cycle after the request.

Top module: `cfgr_router`

## Requirements
- R1: The address carries the bus number in bits 23:16, the device/function field in bits 15:8 (device in 15:11, function in 10:8) and the register offset in bits 7:0. With default parameters, local functions exist at device 0..2 function 0, and secondary functions exist at device 0..1 function 0. Any other function number, any device beyond those, or any bus matching neither segment is absent.
- R2: A read request raises rsp_valid for exactly the following cycle, with the data right-justified in rsp_rdata and the unused upper bits zero. A write request produces no response.
- R3: A read of an absent target returns 0xFF, 0xFFFF or 0xFFFFFFFF for size codes 0, 1 and 2/3 respectively.
- R4: A write to an absent target changes no function register and leaves the secondary bus number unchanged.
- R5: req_size selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. The offset is aligned down to the access width. Byte k of a register dword sits at offset 4n+k, and write data is taken right-justified from req_wdata.
- R6: Each function implements offsets 0x00 to 0x3F. A read at a higher offset of a present function returns zero, and a write there is dropped.
- R7: A 1-byte write to offset 0x19 of the bridge function (local device 2) sets the secondary bus number to req_wdata[7:0].
- R8: A 2- or 4-byte write whose aligned offset is 0x18 in the bridge function sets the secondary bus number to req_wdata[15:8]. A 1-byte write to 0x18 does not change it.
- R9: The secondary bus number resets to 0. While it is 0, no access reaches the secondary segment. When it equals the local bus number, the local segment takes the access.
- R10: After reset every function register reads zero and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_bus | input | 8 | Bus number of the directly attached segment |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Width code: 0 byte, 1 half, 2/3 word |
| req_addr | input | 24 | Bus, device/function and offset |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume that local_bus stays constant while accesses are in flight. They also assume that req_valid pulses once per access, with no other request issued in the cycle a read response is expected. The stimulus holds local_bus at one value for the whole run and issues each access for a single cycle followed by an idle cycle. Random bus numbers are drawn mostly from the local and current secondary numbers, so that hits dominate. Offsets run past 0x3F, so the unimplemented range is exercised as well.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

    localparam logic [7:0] SECBUS_HALF_OFF = 8'h18;
    localparam logic [7:0] SECBUS_BYTE_OFF = 8'h19;

    typedef struct packed {
        logic [7:0]  sec_bus;
        logic        rsp_valid;
        logic [31:0] rsp_rdata;
    } rtr_state_t;

    function automatic logic [7:0] align_off(input logic [7:0] off, input acc_size_e sz);
        case (sz)
            SZ_BYTE: align_off = off;
            SZ_HALF: align_off = {off[7:1], 1'b0};
            default: align_off = {off[7:2], 2'b00};
        endcase
    endfunction

    function automatic logic [3:0] lane_be(input logic [1:0] lo, input acc_size_e sz);
        case (sz)
            SZ_BYTE: lane_be = 4'b0001 << lo;
            SZ_HALF: lane_be = lo[1] ? 4'b1100 : 4'b0011;
            default: lane_be = 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] lane_data(input logic [31:0] wd, input acc_size_e sz);
        case (sz)
            SZ_BYTE: lane_data = {4{wd[7:0]}};
            SZ_HALF: lane_data = {2{wd[15:0]}};
            default: lane_data = wd;
        endcase
    endfunction

    function automatic logic [31:0] pick_read(input logic [31:0] dw, input logic [1:0] lo,
                                              input acc_size_e sz);
        logic [31:0] sh;
        case (sz)
            SZ_BYTE: begin
                sh = dw >> {lo, 3'b000};
                pick_read = {24'h0, sh[7:0]};
            end
            SZ_HALF: begin
                sh = dw >> {lo[1], 4'h0};
                pick_read = {16'h0, sh[15:0]};
            end
            default: pick_read = dw;
        endcase
    endfunction

    function automatic logic [31:0] all_ones(input acc_size_e sz);
        case (sz)
            SZ_BYTE: all_ones = 32'h0000_00FF;
            SZ_HALF: all_ones = 32'h0000_FFFF;
            default: all_ones = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgr_addr_decode.sv
module cfgr_addr_decode
    import cfgr_pkg::*;
#(
    parameter int NLOC       = 3,
    parameter int NSEC       = 2,
    parameter int BRIDGE_DEV = 2,
    parameter int REG_WORDS  = 16,
    localparam int NTGT      = NLOC + NSEC,
    localparam int TGT_W     = (NTGT > 1) ? $clog2(NTGT) : 1,
    localparam int WORD_W    = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1
) (
    input  logic [23:0]       addr,
    input  logic [7:0]        local_bus,
    input  logic [7:0]        sec_bus,
    input  acc_size_e         size,
    output logic              hit,
    output logic [TGT_W-1:0]  tgt,
    output logic              is_bridge,
    output logic              in_space,
    output logic [WORD_W-1:0] word_idx,
    output logic [7:0]        eff_off
);
    localparam int SPACE_BYTES = REG_WORDS * 4;

    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic       on_local;
    logic       on_sec;
    logic       dev_ok;
    int         tgt_int;

    always_comb begin
        bus      = addr[23:16];
        dev      = addr[15:11];
        fn       = addr[10:8];
        eff_off  = align_off(addr[7:0], size);
        on_local = (bus == local_bus);
        on_sec   = !on_local && (sec_bus != 8'h00) && (bus == sec_bus);
        if (on_local)
            dev_ok = (int'(dev) < NLOC);
        else
            dev_ok = (int'(dev) < NSEC);
        hit       = (fn == 3'b000) && (on_local || on_sec) && dev_ok;
        tgt_int   = on_local ? int'(dev) : (NLOC + int'(dev));
        tgt       = hit ? TGT_W'(tgt_int) : '0;
        is_bridge = hit && on_local && (int'(dev) == BRIDGE_DEV);
        in_space  = (int'(eff_off) < SPACE_BYTES);
        word_idx  = WORD_W'(eff_off >> 2);
    end

endmodule

// File: rtl/cfgr_func_regs.sv
module cfgr_func_regs #(
    parameter int REG_WORDS = 16,
    localparam int WORD_W   = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_idx,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic [WORD_W-1:0] rd_idx,
    output logic [31:0]       rd_data
);
    logic [31:0] mem_d [REG_WORDS];
    logic [31:0] mem_q [REG_WORDS];

    always_comb begin
        for (int w = 0; w < REG_WORDS; w++) begin
            mem_d[w] = mem_q[w];
            if (wr_en && (int'(wr_idx) == w)) begin
                for (int b = 0; b < 4; b++) begin
                    if (wr_be[b])
                        mem_d[w][b*8 +: 8] = wr_data[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < REG_WORDS; w++) begin
            if (!rst_n)
                mem_q[w] <= '0;
            else
                mem_q[w] <= mem_d[w];
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/cfgr_secbus_snoop.sv
module cfgr_secbus_snoop
    import cfgr_pkg::*;
(
    input  logic        wr_fire,
    input  logic [7:0]  eff_off,
    input  acc_size_e   size,
    input  logic [31:0] wdata,
    output logic        cap_en,
    output logic [7:0]  cap_val
);
    always_comb begin
        cap_en  = 1'b0;
        cap_val = wdata[7:0];
        if (wr_fire) begin
            if (size == SZ_BYTE) begin
                if (eff_off == SECBUS_BYTE_OFF) begin
                    cap_en  = 1'b1;
                    cap_val = wdata[7:0];
                end
            end else if (eff_off == SECBUS_HALF_OFF) begin
                cap_en  = 1'b1;
                cap_val = wdata[15:8];
            end
        end
    end

endmodule

// File: rtl/cfgr_router.sv
module cfgr_router
    import cfgr_pkg::*;
#(
    parameter int NLOC       = 3,
    parameter int NSEC       = 2,
    parameter int BRIDGE_DEV = 2,
    parameter int REG_WORDS  = 16,
    localparam int NTGT      = NLOC + NSEC,
    localparam int TGT_W     = (NTGT > 1) ? $clog2(NTGT) : 1,
    localparam int WORD_W    = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  local_bus,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [23:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);
    rtr_state_t st_d, st_q;

    acc_size_e         sz;
    logic              dec_hit;
    logic [TGT_W-1:0]  dec_tgt;
    logic              dec_bridge;
    logic              dec_in_space;
    logic [WORD_W-1:0] dec_word;
    logic [7:0]        dec_off;
    logic              wr_fire;
    logic [3:0]        wr_be;
    logic [31:0]       wr_lanes;
    logic              cap_en;
    logic [7:0]        cap_val;
    logic [31:0]       rd_words [NTGT];
    logic [31:0]       sel_word;

    assign sz = acc_size_e'(req_size);

    cfgr_addr_decode #(
        .NLOC(NLOC), .NSEC(NSEC), .BRIDGE_DEV(BRIDGE_DEV), .REG_WORDS(REG_WORDS)
    ) u_dec (
        .addr      (req_addr),
        .local_bus (local_bus),
        .sec_bus   (st_q.sec_bus),
        .size      (sz),
        .hit       (dec_hit),
        .tgt       (dec_tgt),
        .is_bridge (dec_bridge),
        .in_space  (dec_in_space),
        .word_idx  (dec_word),
        .eff_off   (dec_off)
    );

    assign wr_fire  = req_valid && req_write && dec_hit;
    assign wr_be    = lane_be(dec_off[1:0], sz);
    assign wr_lanes = lane_data(req_wdata, sz);

    cfgr_secbus_snoop u_snoop (
        .wr_fire (wr_fire && dec_bridge),
        .eff_off (dec_off),
        .size    (sz),
        .wdata   (req_wdata),
        .cap_en  (cap_en),
        .cap_val (cap_val)
    );

    for (genvar g = 0; g < NTGT; g++) begin : g_func
        cfgr_func_regs #(.REG_WORDS(REG_WORDS)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_fire && dec_in_space && (int'(dec_tgt) == g)),
            .wr_idx  (dec_word),
            .wr_be   (wr_be),
            .wr_data (wr_lanes),
            .rd_idx  (dec_word),
            .rd_data (rd_words[g])
        );
    end

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NTGT; i++) begin
            if (int'(dec_tgt) == i)
                sel_word = rd_words[i];
        end
        if (!dec_in_space)
            sel_word = '0;
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid && !req_write;
        if (req_valid && !req_write) begin
            st_d.rsp_rdata = dec_hit ? pick_read(sel_word, dec_off[1:0], sz) : all_ones(sz);
        end
        if (cap_en)
            st_d.sec_bus = cap_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_rdata;

endmodule

// File: rtl/cfgr_router_checker.sv
module cfgr_router_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic [7:0]  req_bus,
    input logic [7:0]  local_bus,
    input logic        hit,
    input logic [7:0]  sec_bus,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata
);
    AST_READ_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R2

    AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R2

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'b00) |=> (rsp_rdata[31:8] == 24'h0)); // R2

    AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !hit && req_size[1]) |=> (rsp_rdata == 32'hFFFF_FFFF)); // R3

    AST_SECBUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && hit) |=> $stable(sec_bus)); // R4

    AST_NO_FWD_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_bus == 8'h00 && req_bus != local_bus) |-> !hit); // R9

    AST_UNKNOWN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_bus != local_bus && req_bus != sec_bus) |-> !hit); // R1

endmodule

bind cfgr_router cfgr_router_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_bus   (req_addr[23:16]),
    .local_bus (local_bus),
    .hit       (dec_hit),
    .sec_bus   (st_q.sec_bus),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
);

// File: tb/cfgr_router_bench.sv
module cfgr_router_bench;
    localparam logic [7:0] LB = 8'h03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  local_bus = LB;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m_mem [5][16];
    logic [7:0]  m_sec;

    always #4 clk = ~clk;

    cfgr_router u_cfgr_router (
        .clk(clk), .rst_n(rst_n), .local_bus(local_bus),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic int m_lookup(input logic [7:0] bus, input logic [7:0] devfn);
        if (devfn[2:0] != 3'd0) return -1;
        if (bus == LB) return (int'(devfn[7:3]) < 3) ? int'(devfn[7:3]) : -1;
        if (m_sec != 8'h00 && bus == m_sec)
            return (int'(devfn[7:3]) < 2) ? 3 + int'(devfn[7:3]) : -1;
        return -1;
    endfunction

    function automatic logic [7:0] m_align(input logic [7:0] off, input logic [1:0] sz);
        if (sz == 2'd0) return off;
        if (sz == 2'd1) return {off[7:1], 1'b0};
        return {off[7:2], 2'b00};
    endfunction

    function automatic logic [31:0] m_expect(input logic [23:0] a, input logic [1:0] sz);
        int idx;
        logic [7:0] e;
        logic [31:0] w;
        idx = m_lookup(a[23:16], a[15:8]);
        if (idx < 0) return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        e = m_align(a[7:0], sz);
        if (e >= 8'h40) return 32'h0;
        w = m_mem[idx][e[5:2]];
        if (sz == 2'd0) return {24'h0, w[e[1:0]*8 +: 8]};
        if (sz == 2'd1) return {16'h0, w[e[1]*16 +: 16]};
        return w;
    endfunction

    task automatic m_write(input logic [23:0] a, input logic [1:0] sz, input logic [31:0] d);
        int idx;
        logic [7:0] e;
        idx = m_lookup(a[23:16], a[15:8]);
        if (idx < 0) return;
        e = m_align(a[7:0], sz);
        if (e < 8'h40) begin
            if (sz == 2'd0) m_mem[idx][e[5:2]][e[1:0]*8 +: 8] = d[7:0];
            else if (sz == 2'd1) m_mem[idx][e[5:2]][e[1]*16 +: 16] = d[15:0];
            else m_mem[idx][e[5:2]] = d;
        end
        if (idx == 2) begin
            if (sz == 2'd0 && e == 8'h19) m_sec = d[7:0];
            if (sz != 2'd0 && e == 8'h18) m_sec = d[15:8];
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // one access: drive at a falling edge, sample one cycle later
    task automatic access(input bit wr, input logic [23:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input string req);
        logic [31:0] exp;
        exp = m_expect(a, sz);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) begin
            m_write(a, sz, d);
            check({req, " R2 no write response"}, {31'h0, rsp_valid}, 32'h0);
        end else begin
            check({req, " R2 valid"}, {31'h0, rsp_valid}, 32'h1);
            check(req, rsp_rdata, exp);
        end
        @(negedge clk);
    endtask

    function automatic logic [23:0] ad(input logic [7:0] bus, input int dev, input int fn,
                                       input logic [7:0] off);
        return {bus, 5'(dev), 3'(fn), off};
    endfunction

    initial begin
        for (int t = 0; t < 5; t++)
            for (int w = 0; w < 16; w++) m_mem[t][w] = '0;
        m_sec = 8'h00;
        repeat (3) @(negedge clk);
        check("R10 rsp_valid low in reset", {31'h0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 rsp_valid low after reset", {31'h0, rsp_valid}, 32'h0);
        access(0, ad(LB, 0, 0, 8'h00), 2, 0, "R10 reset register");
        access(0, ad(LB, 7, 0, 8'h00), 0, 0, "R3 absent byte");
        access(0, ad(LB, 7, 0, 8'h02), 1, 0, "R3 absent half");
        access(0, ad(LB, 7, 0, 8'h04), 2, 0, "R3 absent word");
        access(0, ad(LB, 0, 1, 8'h00), 3, 0, "R1 nonzero function absent");
        access(0, ad(8'h00, 0, 0, 8'h00), 2, 0, "R9 secondary unset not routed");
        access(1, ad(LB, 1, 0, 8'h10), 2, 32'h1122_3344, "R5 word write");
        access(0, ad(LB, 1, 0, 8'h10), 0, 0, "R5 byte lane 0");
        access(0, ad(LB, 1, 0, 8'h13), 0, 0, "R5 byte lane 3");
        access(0, ad(LB, 1, 0, 8'h12), 1, 0, "R5 upper half");
        access(0, ad(LB, 1, 0, 8'h11), 1, 0, "R5 misaligned half aligns down");
        access(1, ad(LB, 1, 0, 8'h16), 1, 32'hFFFF_A5C3, "R5 half write");
        access(0, ad(LB, 1, 0, 8'h14), 2, 0, "R5 half write lanes");
        access(1, ad(LB, 1, 0, 8'h44), 2, 32'hDEAD_BEEF, "R6 write beyond space");
        access(0, ad(LB, 1, 0, 8'h44), 2, 0, "R6 read beyond space zero");
        access(0, ad(LB, 1, 0, 8'h04), 2, 0, "R6 aliasing not written");
        access(1, ad(LB, 2, 0, 8'h19), 0, 32'h0000_0005, "R7 byte capture");
        access(0, ad(8'h05, 0, 0, 8'h00), 2, 0, "R7 secondary dev0 present");
        access(0, ad(8'h05, 2, 0, 8'h00), 2, 0, "R1 secondary dev2 absent");
        access(1, ad(8'h05, 1, 0, 8'h08), 2, 32'hCAFE_0001, "R7 secondary write");
        access(0, ad(8'h05, 1, 0, 8'h08), 2, 0, "R7 secondary readback");
        access(1, ad(LB, 2, 0, 8'h18), 1, 32'h0000_0900, "R8 half capture");
        access(0, ad(8'h05, 0, 0, 8'h00), 2, 0, "R8 old bus now absent");
        access(0, ad(8'h09, 1, 0, 8'h08), 2, 0, "R8 new bus routed");
        access(1, ad(LB, 2, 0, 8'h1A), 2, 32'h0000_0700, "R8 word capture");
        access(0, ad(8'h07, 1, 0, 8'h08), 2, 0, "R8 word bus routed");
        access(1, ad(LB, 2, 0, 8'h18), 0, 32'h0000_0055, "R8 byte at 0x18 no capture");
        access(0, ad(8'h07, 1, 0, 8'h08), 2, 0, "R8 bus unchanged");
        access(1, ad(8'h42, 0, 0, 8'h00), 2, 32'h1234_5678, "R4 write unknown bus");
        access(1, ad(8'h42, 2, 0, 8'h18), 1, 32'h0000_3300, "R4 write unknown bus bridge offset");
        access(1, ad(LB, 4, 0, 8'h00), 2, 32'h8765_4321, "R4 write absent device");
        access(0, ad(LB, 0, 0, 8'h00), 2, 0, "R4 local dev0 untouched");
        access(0, ad(8'h07, 1, 0, 8'h08), 2, 0, "R4 secondary bus unchanged");
        access(1, ad(LB, 2, 0, 8'h19), 0, {24'h0, LB}, "R9 secondary equals local");
        access(0, ad(LB, 1, 0, 8'h10), 2, 0, "R9 local priority");
        access(1, ad(LB, 2, 0, 8'h19), 0, 32'h0000_0000, "R9 secondary cleared");
        access(0, ad(8'h00, 0, 0, 8'h00), 2, 0, "R9 bus zero not routed");
        access(1, ad(LB, 2, 0, 8'h19), 0, 32'h0000_000B, "R7 set bus B");

        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] bus;
            int sel, dev;
            sel = $urandom_range(9);
            bus = (sel < 5) ? LB : (sel < 8) ? m_sec : 8'($urandom);
            dev = ($urandom_range(7) == 0) ? $urandom_range(31) : $urandom_range(3);
            access($urandom_range(2) == 0, ad(bus, dev, ($urandom_range(9) == 0) ? 1 : 0,
                   8'($urandom_range(8'h4F))), 2'($urandom), $urandom,
                   "R1 R5 R6 random access");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule